// File: doc/BRIEF.md
# Battery status check sequencer

This block is a host-side sequencer that runs once after power-up, and again whenever it is asked. It checks whether a battery-backed byte-wide memory is still healthy. Such a memory blocks the first write after power-up when its backup battery is low. The sequencer detects that block indirectly. It reads one chosen byte, writes the bitwise inverse of that byte to the same place and reads the byte again. If the inverse did not stick, the battery is reported low and the stored data should be treated as possibly corrupt. In either case the original byte is then written back, so the probed location ends up with its old value.

Every memory access uses a request/acknowledge handshake. The request and its address, direction and write data stay fixed until the memory answers with a one-cycle acknowledge. The probed address is a parameter. A second parameter selects where the inverse comparison is made: either directly on the returned read data, which stores only one flag bit, or on a stored copy of the second read. After the restore write, the block raises `done_o` together with the verdict on `batt_low_o`, and holds both until the next start.

Top module: `batt_probe_seq`

## Requirements
- R1: After reset `mem_req_o`, `done_o`, `batt_low_o` and `busy_o` are all 0.
- R2: A start pulse accepted while the block is idle begins a read (`mem_we_o`=0) of address `TEST_ADDR`. Every access of a run uses `TEST_ADDR`, and no other address is touched.
- R3: While `mem_req_o` is 1 and `mem_ack_i` is 0, the request, direction, address and write data stay unchanged. The sequencer never advances without an acknowledge.
- R4: The second access is a write (`mem_we_o`=1) of the bitwise complement of the byte returned by the first read.
- R5: The third access is a read of `TEST_ADDR`.
- R6: If the third access returns exactly the complement, `batt_low_o` is 0 when `done_o` rises.
- R7: If the third access returns anything other than the complement, `batt_low_o` is 1 when `done_o` rises.
- R8: The fourth and last access writes the byte from the first read back to `TEST_ADDR`, in both outcomes. Each run makes exactly four accesses.
- R9: `done_o` rises on the clock edge that accepts the acknowledge of the restore write. `done_o` and `batt_low_o` then hold their values until a new start. `batt_low_o` is never 1 while `done_o` is 0.
- R10: A start pulse while a run is in progress has no effect. The run still makes exactly four accesses and reaches the same verdict.
- R11: A start pulse while `done_o` is 1 clears `done_o` and `batt_low_o` on the next edge and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run a check |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge that completes the current access |
| mem_rdata_i | input | DATA_W | Read data, valid with the acknowledge |
| done_o | output | 1 | Check finished; held until the next start |
| batt_low_o | output | 1 | Verdict: 1 = complement write did not stick |
| busy_o | output | 1 | A run is in progress |

## Verification
The bench builds the block with a 6-bit address, 8-bit data, a probe address of 0x2A and comparison on the returned read data (`CMP_AT_CAPTURE`=1). The other comparison variant is the default that plain elaboration covers. The 64-byte model memory places sentinel bytes on both sides of the probed byte, so a stray address or an extra write becomes visible. The model can block its next write, which brings the low-battery verdict within reach. Its acknowledge latency is adjustable, so the same runs are checked with back-to-back acknowledges and with long waits in which start pulses arrive mid-run.

// File: rtl/bps_pkg.sv
package bps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_ORIG = 3'd1,
      ST_WR_CPL  = 3'd2,
      ST_RD_VFY  = 3'd3,
      ST_WR_BACK = 3'd4,
      ST_FIN     = 3'd5
   } bps_state_e;

   function automatic logic is_access(bps_state_e s);
      return (s == ST_RD_ORIG) || (s == ST_WR_CPL) ||
             (s == ST_RD_VFY)  || (s == ST_WR_BACK);
   endfunction

   function automatic logic is_write(bps_state_e s);
      return (s == ST_WR_CPL) || (s == ST_WR_BACK);
   endfunction

endpackage

// File: rtl/bps_ctrl.sv
module bps_ctrl
   import bps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       ack_i,
   output bps_state_e state_o,
   output logic       take_o,
   output logic       fin_o
);

   bps_state_e st_q, st_d;

   // a start is honoured only when no access is outstanding
   assign take_o = start_i && ((st_q == ST_IDLE) || (st_q == ST_FIN));
   assign fin_o  = (st_q == ST_WR_BACK) && ack_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_FIN: if (start_i) st_d = ST_RD_ORIG;
         ST_RD_ORIG:      if (ack_i)   st_d = ST_WR_CPL;
         ST_WR_CPL:       if (ack_i)   st_d = ST_RD_VFY;
         ST_RD_VFY:       if (ack_i)   st_d = ST_WR_BACK;
         ST_WR_BACK:      if (ack_i)   st_d = ST_FIN;
         default:                      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

endmodule

// File: rtl/bps_port.sv
module bps_port
   import bps_pkg::*;
#(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] TEST_ADDR = '0
) (
   input  bps_state_e        state_i,
   input  logic [DATA_W-1:0] orig_i,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);

   assign req_o  = is_access(state_i);
   assign we_o   = is_write(state_i);
   assign addr_o = TEST_ADDR;

   always_comb begin
      unique case (state_i)
         ST_WR_CPL: wdata_o = ~orig_i;
         default:   wdata_o = orig_i;
      endcase
   end

endmodule

// File: rtl/bps_judge.sv
module bps_judge
   import bps_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter bit          CMP_AT_CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bps_state_e        state_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              take_i,
   input  logic              fin_i,
   output logic [DATA_W-1:0] orig_o,
   output logic              low_o
);

   logic [DATA_W-1:0] orig_q;
   logic              mism;
   logic              low_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                                orig_q <= '0;
      else if ((state_i == ST_RD_ORIG) && ack_i) orig_q <= rdata_i;
   end

   generate
      if (CMP_AT_CAPTURE) begin : g_cmp_capture
         // one flag bit, compare sits on the read-data path
         logic bad_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                               bad_q <= 1'b0;
            else if ((state_i == ST_RD_VFY) && ack_i) bad_q <= (rdata_i != ~orig_q);
         end
         assign mism = bad_q;
      end else begin : g_cmp_stored
         // keep the whole second read, compare from registers
         logic [DATA_W-1:0] vfy_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                               vfy_q <= '0;
            else if ((state_i == ST_RD_VFY) && ack_i) vfy_q <= rdata_i;
         end
         assign mism = (vfy_q != ~orig_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      low_q <= 1'b0;
      else if (take_i) low_q <= 1'b0;
      else if (fin_i)  low_q <= mism;
   end

   assign orig_o = orig_q;
   assign low_o  = low_q;

endmodule

// File: rtl/batt_probe_seq.sv
module batt_probe_seq
   import bps_pkg::*;
#(
   parameter int unsigned ADDR_W         = 11,
   parameter int unsigned DATA_W         = 8,
   parameter logic [ADDR_W-1:0] TEST_ADDR = '0,
   parameter bit          CMP_AT_CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              done_o,
   output logic              batt_low_o,
   output logic              busy_o
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("batt_probe_seq: DATA_W must be at least 1");
   end
   if ((ADDR_W < 1) || (ADDR_W > 30)) begin : g_bad_addr_w
      $error("batt_probe_seq: ADDR_W must be in 1..30");
   end
   if (ADDR_SPAN < 2) begin : g_bad_span
      $error("batt_probe_seq: address space too small");
   end

   bps_state_e        state;
   logic              take;
   logic              fin;
   logic [DATA_W-1:0] orig;

   bps_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .ack_i   (mem_ack_i),
      .state_o (state),
      .take_o  (take),
      .fin_o   (fin)
   );

   bps_port #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .TEST_ADDR (TEST_ADDR)
   ) u_port (
      .state_i (state),
      .orig_i  (orig),
      .req_o   (mem_req_o),
      .we_o    (mem_we_o),
      .addr_o  (mem_addr_o),
      .wdata_o (mem_wdata_o)
   );

   bps_judge #(
      .DATA_W         (DATA_W),
      .CMP_AT_CAPTURE (CMP_AT_CAPTURE)
   ) u_judge (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state),
      .ack_i   (mem_ack_i),
      .rdata_i (mem_rdata_i),
      .take_i  (take),
      .fin_i   (fin),
      .orig_o  (orig),
      .low_o   (batt_low_o)
   );

   assign done_o = (state == ST_FIN);
   assign busy_o = is_access(state);

endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] TEST_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_ack_i,
   input logic [DATA_W-1:0] mem_rdata_i,
   input logic              done_o,
   input logic              batt_low_o
);

   logic [2:0]        acc_n;
   logic [DATA_W-1:0] shadow;

   always_ff @(posedge clk) begin
      if (!rst_n)                      acc_n <= '0;
      else if (done_o)                 acc_n <= '0;
      else if (mem_req_o && mem_ack_i) acc_n <= acc_n + 3'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) shadow <= '0;
      else if (mem_req_o && mem_ack_i && (acc_n == 3'd0)) shadow <= mem_rdata_i;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !mem_req_o && !done_o && !batt_low_o); // R1
   AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o |-> mem_addr_o == TEST_ADDR); // R2
   AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && (acc_n == 3'd0) |-> !mem_we_o); // R2
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R3
   AST_CPL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && (acc_n == 3'd1) |-> mem_we_o && (mem_wdata_o == ~shadow)); // R4
   AST_VERIFY_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && (acc_n == 3'd2) |-> !mem_we_o); // R5
   AST_RESTORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && (acc_n == 3'd3) |-> mem_we_o && (mem_wdata_o == shadow)); // R8
   AST_FOUR_ACCESSES: assert property (@(posedge clk) disable iff (!rst_n) acc_n <= 3'd4); // R8
   AST_LOW_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) batt_low_o |-> done_o); // R9
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) done_o && !start_i |=> done_o && $stable(batt_low_o)); // R9
   AST_DONE_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !mem_req_o); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && !mem_ack_i && start_i |=> mem_req_o && $stable(mem_we_o)); // R10
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) done_o && start_i |=> !done_o && !batt_low_o && mem_req_o); // R11

endmodule

bind batt_probe_seq bps_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .TEST_ADDR (TEST_ADDR)
) u_bps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ack_i   (mem_ack_i),
   .mem_rdata_i (mem_rdata_i),
   .done_o      (done_o),
   .batt_low_o  (batt_low_o)
);

// File: tb/test_batt_probe_seq.sv
`timescale 1ns/1ps
module test_batt_probe_seq;

   localparam int unsigned ADDR_W = 6;
   localparam int unsigned DATA_W = 8;
   localparam logic [ADDR_W-1:0] TA = 6'h2A;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              mem_req_o, mem_we_o;
   logic [ADDR_W-1:0] mem_addr_o;
   logic [DATA_W-1:0] mem_wdata_o;
   logic              mem_ack_i = 1'b0;
   logic [DATA_W-1:0] mem_rdata_i = '0;
   logic              done_o, batt_low_o, busy_o;

   always #2.5 clk = ~clk;

   batt_probe_seq #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .TEST_ADDR      (TA),
      .CMP_AT_CAPTURE (1'b1)
   ) i_batt_probe_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .mem_req_o   (mem_req_o),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_ack_i   (mem_ack_i),
      .mem_rdata_i (mem_rdata_i),
      .done_o      (done_o),
      .batt_low_o  (batt_low_o),
      .busy_o      (busy_o)
   );

   // memory model with a one-shot write block
   logic [DATA_W-1:0] mem [64];
   logic              block = 1'b0;
   int                lat = 0;
   int                wcnt = 0;
   int                cyc = 0;
   int                n_acc = 0;
   int                ack_cyc = 0;
   logic              log_we [8];
   logic [ADDR_W-1:0] log_ad [8];
   logic [DATA_W-1:0] log_d  [8];

   int n_chk = 0;
   int n_fail = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         mem_ack_i <= 1'b0;
         wcnt      <= 0;
      end else begin
         mem_ack_i <= 1'b0;
         if (mem_req_o && !mem_ack_i) begin
            if (wcnt >= lat) begin
               mem_ack_i <= 1'b1;
               wcnt      <= 0;
               ack_cyc   <= cyc;
               if (n_acc < 8) begin
                  log_we[n_acc] <= mem_we_o;
                  log_ad[n_acc] <= mem_addr_o;
                  log_d[n_acc]  <= mem_we_o ? mem_wdata_o : mem[mem_addr_o];
               end
               n_acc <= n_acc + 1;
               if (mem_we_o) begin
                  if (block) block <= 1'b0;
                  else       mem[mem_addr_o] <= mem_wdata_o;
               end else begin
                  mem_rdata_i <= mem[mem_addr_o];
               end
            end else begin
               wcnt <= wcnt + 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run did not end, act cyc=%0d exp <150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic fill_mem();
      for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
   endtask

   // pulse start, wait for done; returns cycles done came after last ack
   task automatic run_seq(output int gap);
      int t;
      n_acc = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      t = 0;
      while (!done_o && t < 2000) begin
         @(negedge clk);
         t++;
      end
      gap = cyc - ack_cyc;
   endtask

   task automatic check_log(input logic [DATA_W-1:0] orig, input string tag);
      chk(n_acc == 4, "R8 access count", n_acc, 4);
      chk(!log_we[0] && log_ad[0] == TA, "R2 first access read of TEST_ADDR", {log_we[0], 2'b0, log_ad[0]}, {1'b0, 2'b0, TA});
      chk(log_we[1] && log_d[1] == ~orig, "R4 complement write", log_d[1], ~orig);
      chk(!log_we[2] && log_ad[2] == TA, "R5 verify read", {log_we[2], 2'b0, log_ad[2]}, {1'b0, 2'b0, TA});
      chk(log_we[3] && log_d[3] == orig && log_ad[3] == TA, "R8 restore write", log_d[3], orig);
      chk(mem[TA] == orig, {"R8 byte restored ", tag}, mem[TA], orig);
      chk(mem[TA-1] == 8'((TA - 1) * 7 + 3) && mem[TA+1] == 8'((TA + 1) * 7 + 3),
          "R2 neighbours untouched", {mem[TA-1], mem[TA+1]},
          {8'((TA - 1) * 7 + 3), 8'((TA + 1) * 7 + 3)});
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!mem_req_o && !done_o && !batt_low_o && !busy_o, "R1 reset outputs",
          {mem_req_o, done_o, batt_low_o, busy_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_ok(input logic [DATA_W-1:0] d, input int l);
      int gap;
      fill_mem();
      mem[TA] = d;
      block = 1'b0;
      lat = l;
      run_seq(gap);
      chk(done_o && !batt_low_o, "R6 healthy verdict", {done_o, batt_low_o}, 2'b10);
      chk(gap == 2, "R9 done timing after restore ack", gap, 2);
      check_log(d, "ok");
   endtask

   task automatic t_low(input logic [DATA_W-1:0] d, input int l);
      int gap;
      fill_mem();
      mem[TA] = d;
      block = 1'b1;
      lat = l;
      run_seq(gap);
      chk(done_o && batt_low_o, "R7 low verdict", {done_o, batt_low_o}, 2'b11);
      chk(gap == 2, "R9 done timing after restore ack", gap, 2);
      chk(!block, "R7 blocked write consumed by complement", block, 0);
      check_log(d, "low");
   endtask

   task automatic t_hold_restart();
      // R9 hold: verdict stays for many idle cycles
      repeat (10) @(negedge clk);
      chk(done_o && batt_low_o, "R9 done and verdict held", {done_o, batt_low_o}, 2'b11);
      chk(!mem_req_o, "R9 port idle while done", mem_req_o, 0);
      lat = 3;
      n_acc = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      chk(!done_o && !batt_low_o && mem_req_o, "R11 restart clears done",
          {done_o, batt_low_o, mem_req_o}, 3'b001);
      for (int t = 0; t < 2000 && !done_o; t++) @(negedge clk);
      chk(done_o && !batt_low_o && n_acc == 4, "R11 new run completes",
          {done_o, batt_low_o, 8'(n_acc)}, {2'b10, 8'd4});
   endtask

   task automatic t_busy_start(input logic blk);
      fill_mem();
      mem[TA] = 8'h3C;
      block = blk;
      lat = 5;
      n_acc = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      // stray starts during accesses 1..3
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         start_i = (k % 3 == 0);
      end
      start_i = 1'b0;
      chk(busy_o && !done_o, "R10 still running after stray start", {busy_o, done_o}, 2'b10);
      for (int t = 0; t < 2000 && !done_o; t++) @(negedge clk);
      chk(n_acc == 4, "R10 four accesses despite stray start", n_acc, 4);
      chk(done_o && batt_low_o == blk, "R10 verdict unaffected", {done_o, batt_low_o}, {1'b1, blk});
      chk(mem[TA] == 8'h3C, "R10 byte restored", mem[TA], 8'h3C);
   endtask

   task automatic t_stall();
      // R3 ack held back: request must not move on
      fill_mem();
      mem[TA] = 8'h96;
      block = 1'b0;
      lat = 40;
      n_acc = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(mem_req_o && !mem_we_o && n_acc == 0, "R3 waits for ack",
          {mem_req_o, mem_we_o, 8'(n_acc)}, {2'b10, 8'd0});
      for (int t = 0; t < 2000 && !done_o; t++) @(negedge clk);
      chk(done_o && !batt_low_o && mem[TA] == 8'h96, "R3 slow run completes",
          {done_o, batt_low_o, mem[TA]}, {2'b10, 8'h96});
   endtask

   initial begin
      fill_mem();
      t_reset();
      t_ok(8'hA5, 0);
      t_ok(8'h00, 2);
      t_ok(8'hFF, 0);
      t_low(8'h5A, 0);
      t_low(8'hFF, 3);
      t_hold_restart();
      t_busy_start(1'b0);
      t_busy_start(1'b1);
      t_stall();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule